// File: doc/BRIEF.md
# Sixteen-bit stack machine core

This block is a small processor that runs stack-oriented, Forth-style primitives, retiring one instruction every clock. Each cycle it fetches a 16-bit word from an instruction port, decodes it as a literal, a jump, a conditional jump, a call or an ALU operation, and updates its machine state: the program counter, a top-of-stack register, a data stack and a return stack. Instruction and data memories are outside the block. Both are read combinationally within the cycle, and a data write takes effect at the next clock edge.

An ALU word has separate fields. One picks the ALU function. Others route T into the stack or onto the return stack, store N to memory, adjust both stack pointers and request a return. All of these act in the same cycle, so an exit from a subroutine can ride on a useful operation at no extra cost. A debug port shows the program counter, T, the entry under T and the top of the return stack.

Top module: `stk_core`

## Requirements
- R1: While reset is high at a clock edge, the PC, T and both stack pointers go to zero and every stack entry is cleared, so all four debug outputs read zero after reset.
- R2: Bits 15..13 select the class: 1xx literal, 000 jump, 001 conditional jump, 010 call, 011 ALU. A literal loads T with bits 14..0 zero-extended, pushes the old T so it becomes N, and advances the PC.
- R3: ALU opcode in bits 11..8: 0 gives T, 1 gives N, 2 gives T+N, 3 gives T AND N, 4 gives T OR N, 5 gives T XOR N, 6 gives NOT T, and 0xC gives the data memory word at address T. Any other opcode leaves T unchanged, and the other fields still act.
- R4: Bits 1..0 move the data stack pointer by a signed delta (00 is 0, 01 is +1, 11 is -1, 10 is -2). Bit 7 writes the old T into the new N slot when the delta is 0 or +1, and it is suppressed when the delta is negative.
- R5: Bit 5 of an ALU word asserts the write strobe for one cycle, with address T and data N. Memory is written only by such words.
- R6: Jump and conditional jump take their target from bits 12..0. A conditional jump branches only when T is zero, otherwise goes to PC+1, and in both cases pops T (N moves into T).
- R7: A call pushes PC+1 onto the return stack and jumps to its target. In an ALU word, bit 12 loads the PC from the top of the return stack in that same cycle, and bits 3..2 move the return pointer with the same delta encoding as R4.
- R8: Bit 6 of an ALU word writes the old T into the return stack entry at the new return pointer.
- R9: Each stack holds 16 entries, and its pointer wraps modulo the depth, so a seventeenth push overwrites the oldest entry.
- R10: These words execute with the meaning named: 0x6081 duplicate, 0x6183 drop, 0x6180 swap, 0x6181 over, 0x6203 add, 0x6303 and, 0x6403 or, 0x6503 xor, 0x6600 invert, 0x6C00 fetch, 0x6123 store N at T and pop one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 13 | Fetch address, equal to the PC |
| imem_data | input | 16 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 16 | Data address, always T |
| dmem_wdata | output | 16 | Store data, always N |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 16 | Data word at dmem_addr, same cycle |
| dbg_pc | output | 13 | Current PC |
| dbg_t | output | 16 | Top of data stack |
| dbg_n | output | 16 | Entry under the top of data stack |
| dbg_r | output | 16 | Top of return stack |

## Verification
The assertions take for granted that the instruction and data words arrive combinationally in the cycle their addresses are shown, and that reset is held for at least one clock edge before the checks apply. The bench meets this by serving both memories from arrays read on the live address and by holding reset for two edges before each program. The programs keep every branch target inside the preloaded region, so no check depends on the contents of unloaded memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int WORD_W = 16;
    localparam int PC_W   = 13;

    typedef enum logic [2:0] {
        CL_LIT, CL_JMP, CL_CJMP, CL_CALL, CL_ALU
    } iclass_e;

    localparam logic [3:0] OP_T    = 4'h0;
    localparam logic [3:0] OP_N    = 4'h1;
    localparam logic [3:0] OP_ADD  = 4'h2;
    localparam logic [3:0] OP_AND  = 4'h3;
    localparam logic [3:0] OP_OR   = 4'h4;
    localparam logic [3:0] OP_XOR  = 4'h5;
    localparam logic [3:0] OP_INV  = 4'h6;
    localparam logic [3:0] OP_LOAD = 4'hC;

    typedef struct packed {
        iclass_e           cls;
        logic [3:0]        alu_op;
        logic              ret;
        logic              t_to_n;
        logic              t_to_r;
        logic              n_to_mem;
        logic [1:0]        rdelta;
        logic [1:0]        ddelta;
        logic [PC_W-1:0]   target;
        logic [WORD_W-1:0] lit_val;
    } dec_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    always_comb begin
        dec.alu_op   = instr[11:8];
        dec.ret      = instr[12];
        dec.t_to_n   = instr[7];
        dec.t_to_r   = instr[6];
        dec.n_to_mem = instr[5];
        dec.rdelta   = instr[3:2];
        dec.ddelta   = instr[1:0];
        dec.target   = instr[PC_W-1:0];
        dec.lit_val  = {1'b0, instr[14:0]};
        casez (instr[15:13])
            3'b1??:  dec.cls = CL_LIT;
            3'b000:  dec.cls = CL_JMP;
            3'b001:  dec.cls = CL_CJMP;
            3'b010:  dec.cls = CL_CALL;
            default: dec.cls = CL_ALU;
        endcase
    end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
(
    input  logic [3:0]        op,
    input  logic [WORD_W-1:0] t_val,
    input  logic [WORD_W-1:0] n_val,
    input  logic [WORD_W-1:0] mem_val,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        case (op)
            OP_T:    result = t_val;
            OP_N:    result = n_val;
            OP_ADD:  result = t_val + n_val;
            OP_AND:  result = t_val & n_val;
            OP_OR:   result = t_val | n_val;
            OP_XOR:  result = t_val ^ n_val;
            OP_INV:  result = ~t_val;
            OP_LOAD: result = mem_val;
            default: result = t_val;
        endcase
    end
endmodule

// File: rtl/stk_lifo.sv
module stk_lifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] ent_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[waddr] <= wdata;
        end
    end

    assign rdata = ent_q[raddr];
endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int DSTACK_DEPTH = 16,
    parameter int RSTACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [WORD_W-1:0] imem_data,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic [PC_W-1:0]   dbg_pc,
    output logic [WORD_W-1:0] dbg_t,
    output logic [WORD_W-1:0] dbg_n,
    output logic [WORD_W-1:0] dbg_r
);
    localparam int DPW = $clog2(DSTACK_DEPTH);
    localparam int RPW = $clog2(RSTACK_DEPTH);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [WORD_W-1:0] t;
        logic [DPW-1:0]    dsp;
        logic [RPW-1:0]    rsp;
    } core_st_t;

    core_st_t st_d, st_q;
    dec_t     dec;

    logic [WORD_W-1:0] n_val, r_val, alu_res;
    logic              ds_we_d, rs_we_d;
    logic [DPW-1:0]    ds_waddr_d, dsp_step;
    logic [RPW-1:0]    rs_waddr_d, rsp_step;
    logic [WORD_W-1:0] ds_wdata_d, rs_wdata_d;
    logic [PC_W-1:0]   pc_inc;
    logic              store_d;

    stk_decode u_dec (.instr(imem_data), .dec(dec));

    stk_alu u_alu (
        .op(dec.alu_op), .t_val(st_q.t), .n_val(n_val),
        .mem_val(dmem_rdata), .result(alu_res)
    );

    stk_lifo #(.DEPTH(DSTACK_DEPTH), .W(WORD_W)) u_dstk (
        .clk(clk), .rst(rst), .we(ds_we_d), .waddr(ds_waddr_d),
        .wdata(ds_wdata_d), .raddr(st_q.dsp), .rdata(n_val)
    );

    stk_lifo #(.DEPTH(RSTACK_DEPTH), .W(WORD_W)) u_rstk (
        .clk(clk), .rst(rst), .we(rs_we_d), .waddr(rs_waddr_d),
        .wdata(rs_wdata_d), .raddr(st_q.rsp), .rdata(r_val)
    );

    always_comb begin
        pc_inc     = st_q.pc + 1'b1;
        dsp_step   = st_q.dsp + DPW'({{(DPW-2){dec.ddelta[1]}}, dec.ddelta});
        rsp_step   = st_q.rsp + RPW'({{(RPW-2){dec.rdelta[1]}}, dec.rdelta});
        st_d       = st_q;
        st_d.pc    = pc_inc;
        ds_we_d    = 1'b0;
        ds_waddr_d = st_q.dsp + 1'b1;
        ds_wdata_d = st_q.t;
        rs_we_d    = 1'b0;
        rs_waddr_d = st_q.rsp + 1'b1;
        rs_wdata_d = st_q.t;
        store_d    = 1'b0;
        case (dec.cls)
            CL_LIT: begin
                st_d.t   = dec.lit_val;
                st_d.dsp = st_q.dsp + 1'b1;
                ds_we_d  = 1'b1;
            end
            CL_JMP: st_d.pc = dec.target;
            CL_CJMP: begin
                st_d.pc  = (st_q.t == '0) ? dec.target : pc_inc;
                st_d.t   = n_val;
                st_d.dsp = st_q.dsp - 1'b1;
            end
            CL_CALL: begin
                st_d.pc    = dec.target;
                st_d.rsp   = st_q.rsp + 1'b1;
                rs_we_d    = 1'b1;
                rs_wdata_d = WORD_W'(pc_inc);
            end
            CL_ALU: begin
                st_d.t     = alu_res;
                st_d.dsp   = dsp_step;
                st_d.rsp   = rsp_step;
                ds_waddr_d = dsp_step;
                ds_we_d    = dec.t_to_n & ~dec.ddelta[1];
                rs_waddr_d = rsp_step;
                rs_we_d    = dec.t_to_r;
                store_d    = dec.n_to_mem;
                if (dec.ret) st_d.pc = r_val[PC_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = st_q.t;
    assign dmem_wdata = n_val;
    assign dmem_we    = store_d & ~rst;
    assign dbg_pc     = st_q.pc;
    assign dbg_t      = st_q.t;
    assign dbg_n      = n_val;
    assign dbg_r      = r_val;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (dbg_pc == '0 && dbg_t == '0 && dbg_n == '0 && dbg_r == '0));

    a_r2_literal_push: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15] == 1'b1) |=>
            (dbg_t == {1'b0, $past(imem_data[14:0])} && dbg_n == $past(dbg_t)));

    a_r6_cjump_taken: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15:13] == 3'b001 && dbg_t == '0) |=>
            (dbg_pc == $past(imem_data[PC_W-1:0]) && dbg_t == $past(dbg_n)));

    a_r7_call_link: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15:13] == 3'b010) |=>
            (dbg_pc == $past(imem_data[PC_W-1:0]) &&
             dbg_r == WORD_W'($past(dbg_pc) + 1'b1)));

    a_r7_return_pc: assert property (@(posedge clk) disable iff (rst)
        (imem_data[15:12] == 4'b0111) |=> (dbg_pc == $past(dbg_r[PC_W-1:0])));

    a_r5_store_only_alu: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_data[15:13] == 3'b011 && imem_data[5]));
endmodule

// File: tb/stk_core_bench.sv
module stk_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] imem_addr;
    logic [15:0] imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [12:0] dbg_pc;
    logic [15:0] dbg_t, dbg_n, dbg_r;

    logic [15:0] imem [64];
    logic [15:0] dmem [256];
    logic        mem_clr = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int          mpc, mdsp, mrsp;
    logic [15:0] mt;
    logic [15:0] mds [16];
    logic [15:0] mrs [16];
    logic [15:0] mm  [256];
    string       mtag;

    always #10 clk = ~clk;

    stk_core u_stk_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_t(dbg_t),
        .dbg_n(dbg_n), .dbg_r(dbg_r)
    );

    assign imem_data  = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_clr) begin
            for (int i = 0; i < 256; i++) dmem[i] <= '0;
        end else if (dmem_we) begin
            dmem[dmem_addr[7:0]] <= dmem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (pc %0d)", req, act, exp, mpc);
        end
    endtask

    function automatic int delta(input logic [1:0] d);
        case (d)
            2'b01:   return 1;
            2'b11:   return -1;
            2'b10:   return -2;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        mpc = 0; mdsp = 0; mrsp = 0; mt = '0;
        for (int i = 0; i < 16; i++) begin mds[i] = '0; mrs[i] = '0; end
        mtag = "R1";
    endtask

    task automatic compare_state();
        chk(dbg_pc == mpc[12:0], mtag, {19'b0, dbg_pc}, mpc);
        chk(dbg_t == mt,         mtag, {16'b0, dbg_t}, {16'b0, mt});
        chk(dbg_n == mds[mdsp],  "R4 N", {16'b0, dbg_n}, {16'b0, mds[mdsp]});
        chk(dbg_r == mrs[mrsp],  "R7 R8 return top", {16'b0, dbg_r}, {16'b0, mrs[mrsp]});
    endtask

    // advance the model by one instruction and check this cycle's store
    task automatic model_step();
        logic [15:0] ins, res, oldt, n;
        bit          st_exp;
        int          nd, nr;
        ins  = imem[mpc[5:0]];
        oldt = mt;
        n    = mds[mdsp];
        st_exp = 0;
        if (ins[15]) begin                       // R2 literal
            mdsp = (mdsp + 1) & 15;
            mds[mdsp] = oldt;
            mt = {1'b0, ins[14:0]};
            mpc = mpc + 1;
            mtag = "R2 literal";
        end else if (ins[14:13] == 2'b00) begin  // R6 jump
            mpc = ins[12:0];
            mtag = "R6 jump";
        end else if (ins[14:13] == 2'b01) begin  // R6 conditional
            mpc = (oldt == 0) ? int'(ins[12:0]) : mpc + 1;
            mt = n;
            mdsp = (mdsp - 1) & 15;
            mtag = "R6 cjump";
        end else if (ins[14:13] == 2'b10) begin  // R7 call
            mrsp = (mrsp + 1) & 15;
            mrs[mrsp] = 16'(mpc + 1);
            mpc = ins[12:0];
            mtag = "R7 call";
        end else begin                           // R3 ALU
            case (ins[11:8])
                4'h0: res = oldt;
                4'h1: res = n;
                4'h2: res = oldt + n;
                4'h3: res = oldt & n;
                4'h4: res = oldt | n;
                4'h5: res = oldt ^ n;
                4'h6: res = ~oldt;
                4'hC: res = mm[oldt[7:0]];
                default: res = oldt;
            endcase
            nd = (mdsp + delta(ins[1:0])) & 15;
            nr = (mrsp + delta(ins[3:2])) & 15;
            if (ins[12]) mpc = mrs[mrsp][12:0];
            else mpc = mpc + 1;
            if (ins[7] && !ins[1]) mds[nd] = oldt;
            if (ins[6]) mrs[nr] = oldt;
            if (ins[5]) begin
                st_exp = 1;
                mm[oldt[7:0]] = n;
            end
            mdsp = nd; mrsp = nr; mt = res;
            mtag = ins[12] ? "R7 return" : (ins[6] ? "R8" : "R3 R10");
        end
        chk(dmem_we == st_exp, "R5 strobe", {31'b0, dmem_we}, {31'b0, st_exp});
        if (st_exp) begin
            chk(dmem_addr == oldt, "R5 addr", {16'b0, dmem_addr}, {16'b0, oldt});
            chk(dmem_wdata == n,   "R5 data", {16'b0, dmem_wdata}, {16'b0, n});
        end
    endtask

    task automatic start_prog();
        rst = 1'b1;
        mem_clr = 1'b1;
        for (int i = 0; i < 256; i++) mm[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mem_clr = 1'b0;
        model_reset();
    endtask

    task automatic run(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            compare_state();
            model_step();
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = 16'h0000;
        // program 1: ALU words, call/return, countdown, return-stack copy
        imem[0]  = 16'h8005; imem[1]  = 16'h8003; imem[2]  = 16'h6203;
        imem[3]  = 16'h6081; imem[4]  = 16'h8007; imem[5]  = 16'h6503;
        imem[6]  = 16'h6181; imem[7]  = 16'h6180; imem[8]  = 16'h6303;
        imem[9]  = 16'h6403; imem[10] = 16'h6600; imem[11] = 16'h8020;
        imem[12] = 16'h6123; imem[13] = 16'h8020; imem[14] = 16'h6C00;
        imem[15] = 16'h6183; imem[16] = 16'h4014; imem[17] = 16'h0018;
        imem[20] = 16'h9234; imem[21] = 16'h700C;
        imem[24] = 16'h8003; imem[25] = 16'h6081; imem[26] = 16'h201F;
        imem[27] = 16'h8000; imem[28] = 16'h6600; imem[29] = 16'h6203;
        imem[30] = 16'h0019;
        imem[31] = 16'h8023; imem[32] = 16'h6044; imem[33] = 16'h700C;
        imem[34] = 16'h0022; imem[35] = 16'h6700; imem[36] = 16'h6E00;
        imem[37] = 16'h0025;

        start_prog();
        // R1: state right after reset
        chk(dbg_pc == 0 && dbg_t == 0 && dbg_n == 0 && dbg_r == 0, "R1 reset",
            {dbg_t, 3'b0, dbg_pc}, 32'h0);
        run(90);
        chk(dbg_pc == 13'd37, "R7 R8 final pc", {19'b0, dbg_pc}, 32'd37);
        chk(dmem[32] == 16'hFFF7, "R5 R10 stored word", {16'b0, dmem[32]}, 32'hFFF7);

        // program 2: stack wrap after 18 pushes
        for (int i = 0; i < 64; i++) imem[i] = 16'h0000;
        for (int k = 0; k < 18; k++) imem[k] = 16'h8000 | 16'(k + 1);
        for (int k = 18; k < 22; k++) imem[k] = 16'h6103;
        imem[22] = 16'h0016;
        start_prog();
        run(30);
        // after 18 pushes and 4 pops T = 14; wrapped entries were overwritten
        chk(dbg_t == 16'd14, "R9 wrap top", {16'b0, dbg_t}, 32'd14);

        // mid-run reset returns to the reset state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(dbg_pc == 0 && dbg_t == 0 && dbg_n == 0 && dbg_r == 0, "R1 mid reset",
            {dbg_t, 3'b0, dbg_pc}, 32'h0);
        rst = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule